// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Fast-Path Steering

This block collects level-sensitive interrupt lines into three banks: a small direct bank of 8 lines and two wide banks of 32 lines each. Every bank has its own mask. Software sets mask bits through a write-one-to-set port and clears them through a write-one-to-clear port. A per-bank pending view shows the lines that are active and unmasked. The bank 0 pending word is the top-level status word. It shows the direct lines, one summary flag for each wide bank, and a fixed set of shortcut flags. Each shortcut flag copies one chosen wide-bank line, so a handler can identify the most common sources from a single read.

A line that has a shortcut never raises its bank's summary flag. Such a line is masked only through its own bank's mask. The summary flags have no mask. A steering register can pick any one of the 72 lines and drive it onto a separate fast interrupt output. That line is then removed from the normal interrupt output. Input lines pass through one register stage before they are used.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, all three masks and the steering register are zero, all pending views read zero, and `irq_o` and `fiq_o` are low.
- R2: Byte addresses are as follows. Pending views: bank 0 at 0x00, bank 1 at 0x04, bank 2 at 0x08. Mask-set ports: bank 1 at 0x10, bank 2 at 0x14, bank 0 at 0x18. Mask-clear ports: bank 1 at 0x1C, bank 2 at 0x20, bank 0 at 0x24. Steering register at 0x0C. Writes to the pending views change nothing, and any other address reads zero.
- R3: Writing a 1 to a bit of a mask-set port sets that mask bit. Writing a 1 to a bit of a mask-clear port clears it. Zero bits leave the mask unchanged. Both ports of a bank read back the current mask, visible after the write's clock edge.
- R4: A wide-bank pending bit equals the sampled line ANDed with its mask bit. It follows the line one clock after the input changes, and it drops when the line drops.
- R5: Bank 0 pending bits 7:0 are the masked direct lines. Bit 8 is set when any pending bank 1 line that has no shortcut is present. Bit 9 does the same for bank 2.
- R6: Bank 0 pending bits 14:10 copy bank 1 pending bits 7, 9, 10, 18 and 19, in that order. Bits 20:15 copy bank 2 pending bits 21, 22, 23, 24, 25 and 30, in that order. Lines with a shortcut never set bit 8 or bit 9. Bits 31:21 read zero.
- R7: The bank 0 mask has only 8 bits. Bits 31:8 written to 0x18 or 0x24 have no effect, so shortcut and summary bits cannot be masked there. Shortcut lines obey only their own bank's mask.
- R8: The steering register keeps written bits 7:0 and reads zero above them. Bits 6:0 select a line: 0–31 select bank 1, 32–63 select bank 2, 64–71 select bank 0, and 72–127 select no line. Bit 7 enables steering.
- R9: `fiq_o` is high exactly when steering is enabled and the selected sampled line is active, whatever that line's mask bit is.
- R10: `irq_o` is high when any pending line (direct, bank 1 or bank 2) is present, other than the line currently steered to `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_b0_i | input | 8 | Direct bank level lines |
| src_b1_i | input | 32 | Wide bank 1 level lines |
| src_b2_i | input | 32 | Wide bank 2 level lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high with req_i |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a line that is pending and unmasked but also steered to the fast output. Here the line must stay visible in its pending view, drop out of `irq_o`, and still drive `fiq_o`. A second hard case is a shortcut line that shows up in bank 0 without raising its bank's summary flag. The stimulus sweeps a single active line across every position of each bank, with all masks open, so each shortcut and non-shortcut position is visited. It then sweeps the steering index over all 72 valid lines and a run of invalid indices. This is done with all lines active and masks closed, and again with a single unmasked line, so that steered and unsteered pending lines are compared at the outputs.

// File: rtl/banked_irq_pkg.sv
package banked_irq_pkg;
  localparam int unsigned N_B0     = 8;
  localparam int unsigned N_WIDE   = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned SEL_W    = 7;
  localparam int unsigned SC1_N    = 5;
  localparam int unsigned SC2_N    = 6;
  localparam int unsigned SUM1_BIT = N_B0;
  localparam int unsigned SUM2_BIT = N_B0 + 1;
  localparam int unsigned SC1_LSB  = N_B0 + 2;
  localparam int unsigned SC2_LSB  = SC1_LSB + SC1_N;
  localparam int unsigned P0_W     = SC2_LSB + SC2_N;
  localparam int unsigned B1_BASE  = 0;
  localparam int unsigned B2_BASE  = N_WIDE;
  localparam int unsigned B0_BASE  = 2 * N_WIDE;

  // shortcut source positions, order defines the bank 0 bit order
  localparam int unsigned SC1_POS [SC1_N] = '{7, 9, 10, 18, 19};
  localparam int unsigned SC2_POS [SC2_N] = '{21, 22, 23, 24, 25, 30};

  localparam logic [ADDR_W-1:0] A_PEND0 = 6'h00;
  localparam logic [ADDR_W-1:0] A_PEND1 = 6'h04;
  localparam logic [ADDR_W-1:0] A_PEND2 = 6'h08;
  localparam logic [ADDR_W-1:0] A_STEER = 6'h0C;
  localparam logic [ADDR_W-1:0] A_SET1  = 6'h10;
  localparam logic [ADDR_W-1:0] A_SET2  = 6'h14;
  localparam logic [ADDR_W-1:0] A_SET0  = 6'h18;
  localparam logic [ADDR_W-1:0] A_CLR1  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_CLR2  = 6'h20;
  localparam logic [ADDR_W-1:0] A_CLR0  = 6'h24;

  function automatic logic [N_WIDE-1:0] sc1_mask();
    logic [N_WIDE-1:0] m = '0;
    for (int k = 0; k < SC1_N; k++) m[SC1_POS[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [N_WIDE-1:0] sc2_mask();
    logic [N_WIDE-1:0] m = '0;
    for (int k = 0; k < SC2_N; k++) m[SC2_POS[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (set_i) mask_q <= mask_q | bits_i;
    else if (clr_i) mask_q <= mask_q & ~bits_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_bank0_compose.sv
module irq_bank0_compose
  import banked_irq_pkg::*;
(
  input  logic [N_B0-1:0]   pend_b0_i,
  input  logic [N_WIDE-1:0] pend_b1_i,
  input  logic [N_WIDE-1:0] pend_b2_i,
  output logic [P0_W-1:0]   pend0_o
);
  localparam logic [N_WIDE-1:0] SC1_M = sc1_mask();
  localparam logic [N_WIDE-1:0] SC2_M = sc2_mask();

  logic [SC1_N-1:0] sc1;
  logic [SC2_N-1:0] sc2;

  for (genvar k = 0; k < SC1_N; k++) begin : g_sc1
    assign sc1[k] = pend_b1_i[SC1_POS[k]];
  end
  for (genvar k = 0; k < SC2_N; k++) begin : g_sc2
    assign sc2[k] = pend_b2_i[SC2_POS[k]];
  end

  // shortcut lines are kept out of the summary flags
  assign pend0_o = {sc2, sc1,
                    |(pend_b2_i & ~SC2_M),
                    |(pend_b1_i & ~SC1_M),
                    pend_b0_i};
endmodule

// File: rtl/irq_fiq_route.sv
module irq_fiq_route
  import banked_irq_pkg::*;
(
  input  logic [7:0]        steer_i,
  input  logic [N_B0-1:0]   raw_b0_i,
  input  logic [N_WIDE-1:0] raw_b1_i,
  input  logic [N_WIDE-1:0] raw_b2_i,
  output logic [N_B0-1:0]   sel_b0_o,
  output logic [N_WIDE-1:0] sel_b1_o,
  output logic [N_WIDE-1:0] sel_b2_o,
  output logic              fiq_o
);
  logic             en;
  logic [SEL_W-1:0] idx;

  assign en  = steer_i[7];
  assign idx = steer_i[SEL_W-1:0];

  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    assign sel_b1_o[i] = en && (idx == SEL_W'(B1_BASE + i));
    assign sel_b2_o[i] = en && (idx == SEL_W'(B2_BASE + i));
  end
  for (genvar i = 0; i < N_B0; i++) begin : g_b0
    assign sel_b0_o[i] = en && (idx == SEL_W'(B0_BASE + i));
  end

  assign fiq_o = |(sel_b0_o & raw_b0_i) | |(sel_b1_o & raw_b1_i) | |(sel_b2_o & raw_b2_i);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import banked_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_B0-1:0]   src_b0_i,
  input  logic [N_WIDE-1:0] src_b1_i,
  input  logic [N_WIDE-1:0] src_b2_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic              wr;
  logic [N_B0-1:0]   raw_b0;
  logic [N_WIDE-1:0] raw_b1, raw_b2;
  logic [N_B0-1:0]   en_b0;
  logic [N_WIDE-1:0] en_b1, en_b2;
  logic [7:0]        steer_q;
  logic [N_B0-1:0]   pend_b0, sel_b0;
  logic [N_WIDE-1:0] pend_b1, pend_b2, sel_b1, sel_b2;
  logic [P0_W-1:0]   pend0;

  assign wr = req_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_b0 <= '0;
      raw_b1 <= '0;
      raw_b2 <= '0;
    end else begin
      raw_b0 <= src_b0_i;
      raw_b1 <= src_b1_i;
      raw_b2 <= src_b2_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       steer_q <= '0;
    else if (wr && addr_i == A_STEER)  steer_q <= wdata_i[7:0];
  end

  irq_mask_reg #(.W(N_B0)) u_mask0 (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == A_SET0),
    .clr_i (wr && addr_i == A_CLR0),
    .bits_i(wdata_i[N_B0-1:0]),
    .mask_o(en_b0)
  );
  irq_mask_reg #(.W(N_WIDE)) u_mask1 (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == A_SET1),
    .clr_i (wr && addr_i == A_CLR1),
    .bits_i(wdata_i),
    .mask_o(en_b1)
  );
  irq_mask_reg #(.W(N_WIDE)) u_mask2 (
    .clk_i, .rst_ni,
    .set_i (wr && addr_i == A_SET2),
    .clr_i (wr && addr_i == A_CLR2),
    .bits_i(wdata_i),
    .mask_o(en_b2)
  );

  assign pend_b0 = raw_b0 & en_b0;
  assign pend_b1 = raw_b1 & en_b1;
  assign pend_b2 = raw_b2 & en_b2;

  irq_bank0_compose u_compose (
    .pend_b0_i(pend_b0),
    .pend_b1_i(pend_b1),
    .pend_b2_i(pend_b2),
    .pend0_o  (pend0)
  );

  irq_fiq_route u_route (
    .steer_i (steer_q),
    .raw_b0_i(raw_b0),
    .raw_b1_i(raw_b1),
    .raw_b2_i(raw_b2),
    .sel_b0_o(sel_b0),
    .sel_b1_o(sel_b1),
    .sel_b2_o(sel_b2),
    .fiq_o   (fiq_o)
  );

  // the steered line leaves the normal request
  assign irq_o = |(pend_b0 & ~sel_b0) | |(pend_b1 & ~sel_b1) | |(pend_b2 & ~sel_b2);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PEND0:         rdata_o = DATA_W'(pend0);
      A_PEND1:         rdata_o = pend_b1;
      A_PEND2:         rdata_o = pend_b2;
      A_STEER:         rdata_o = DATA_W'(steer_q);
      A_SET0, A_CLR0:  rdata_o = DATA_W'(en_b0);
      A_SET1, A_CLR1:  rdata_o = en_b1;
      A_SET2, A_CLR2:  rdata_o = en_b2;
      default:         rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk
  import banked_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [N_B0-1:0]   en_b0,
  input logic [N_WIDE-1:0] en_b1,
  input logic [N_WIDE-1:0] en_b2,
  input logic [7:0]        steer_q,
  input logic [N_B0-1:0]   raw_b0,
  input logic [N_WIDE-1:0] raw_b1,
  input logic [N_WIDE-1:0] raw_b2
);
  p_set1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_SET1) |=> ((en_b1 & $past(wdata_i)) == $past(wdata_i)));

  p_clr2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_CLR2) |=> ((en_b2 & $past(wdata_i)) == '0));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(en_b0) && $stable(en_b1) && $stable(en_b2) && $stable(steer_q)));

  p_fiq_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !steer_q[7] |-> !fiq_o);

  p_fiq_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (steer_q[6:0] >= 7'd72) |-> !fiq_o);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_b0 == '0 && raw_b1 == '0 && raw_b2 == '0) |-> (!irq_o && !fiq_o));

  p_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_b0 == '0 && en_b1 == '0 && en_b2 == '0) |-> !irq_o);
endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .irq_o, .fiq_o,
  .en_b0, .en_b1, .en_b2, .steer_q, .raw_b0, .raw_b1, .raw_b2
);

// File: tb/banked_irq_ctrl_tb.sv
module banked_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  src_b0_i = '0;
  logic [31:0] src_b1_i = '0, src_b2_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_run = 0, n_fail = 0;

  // bench model state
  logic [7:0]  m_s0 = '0, m_e0 = '0;
  logic [31:0] m_s1 = '0, m_s2 = '0, m_e1 = '0, m_e2 = '0;
  logic [7:0]  m_st = '0;

  always #5 clk_i = ~clk_i;

  banked_irq_ctrl u_dut (.*);

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic drive(logic [7:0] s0, logic [31:0] s1, logic [31:0] s2);
    @(negedge clk_i);
    src_b0_i = s0; src_b1_i = s1; src_b2_i = s2;
    m_s0 = s0; m_s1 = s1; m_s2 = s2;
    @(negedge clk_i);
  endtask

  function automatic logic [31:0] exp_p0();
    logic [31:0] p1 = m_s1 & m_e1, p2 = m_s2 & m_e2, r = '0;
    r[7:0] = m_s0 & m_e0;
    r[8] = |(p1 & ~(32'h1 << 7 | 32'h1 << 9 | 32'h1 << 10 | 32'h1 << 18 | 32'h1 << 19));
    r[9] = |(p2 & ~(32'h1 << 21 | 32'h1 << 22 | 32'h1 << 23 | 32'h1 << 24 | 32'h1 << 25 | 32'h1 << 30));
    r[10] = p1[7];  r[11] = p1[9];  r[12] = p1[10]; r[13] = p1[18]; r[14] = p1[19];
    r[15] = p2[21]; r[16] = p2[22]; r[17] = p2[23]; r[18] = p2[24]; r[19] = p2[25]; r[20] = p2[30];
    return r;
  endfunction

  function automatic logic [71:0] raw_all();
    return {m_s0, m_s2, m_s1};
  endfunction

  function automatic logic [71:0] pend_all();
    return {m_s0 & m_e0, m_s2 & m_e2, m_s1 & m_e1};
  endfunction

  function automatic logic exp_fiq();
    int idx = int'(m_st[6:0]);
    logic [71:0] r = raw_all();
    return m_st[7] && idx < 72 && r[idx];
  endfunction

  function automatic logic exp_irq();
    logic [71:0] p = pend_all();
    int idx = int'(m_st[6:0]);
    if (m_st[7] && idx < 72) p[idx] = 1'b0;
    return |p;
  endfunction

  task automatic full(string tag);
    logic [31:0] d;
    rd(6'h00, d); chk({tag, " pend0 R5 R6"}, d, exp_p0());
    rd(6'h04, d); chk({tag, " pend1 R4"}, d, m_s1 & m_e1);
    rd(6'h08, d); chk({tag, " pend2 R4"}, d, m_s2 & m_e2);
    chk({tag, " irq R10"}, {31'b0, irq_o}, {31'b0, exp_irq()});
    chk({tag, " fiq R9"}, {31'b0, fiq_o}, {31'b0, exp_fiq()});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(6'(a * 4), d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 irq low", {31'b0, irq_o}, 32'h0);
    chk("R1 fiq low", {31'b0, fiq_o}, 32'h0);

    // R3 / R7 mask ports
    wr(6'h18, 32'hFFFF_FFFF); m_e0 = 8'hFF;
    rd(6'h18, d); chk("R7 b0 mask width", d, 32'hFF);
    rd(6'h24, d); chk("R3 clr port reads mask", d, 32'hFF);
    wr(6'h10, 32'h0000_FFFF); wr(6'h10, 32'hFFFF_0000); m_e1 = '1;
    rd(6'h10, d); chk("R3 set accumulates", d, 32'hFFFF_FFFF);
    wr(6'h14, 32'hFFFF_FFFF); wr(6'h20, 32'h0000_00F0); m_e2 = 32'hFFFF_FF0F;
    rd(6'h14, d); chk("R3 w1c", d, 32'hFFFF_FF0F);
    wr(6'h14, 32'h0000_00F0); m_e2 = '1;
    rd(6'h20, d); chk("R3 w1s restore", d, 32'hFFFF_FFFF);

    // R2 writes to pending and unused addresses
    wr(6'h00, 32'hFFFF_FFFF); wr(6'h04, 32'hFFFF_FFFF); wr(6'h3C, 32'hFFFF_FFFF);
    rd(6'h3C, d); chk("R2 unmapped reads zero", d, 0);
    full("R2 pending write ignored");

    // single-line sweeps with all masks open
    for (int i = 0; i < 32; i++) begin drive(0, 32'h1 << i, 0); full($sformatf("R6 b1 line %0d", i)); end
    for (int i = 0; i < 32; i++) begin drive(0, 0, 32'h1 << i); full($sformatf("R6 b2 line %0d", i)); end
    for (int i = 0; i < 8; i++)  begin drive(8'h1 << i, 0, 0); full($sformatf("R5 b0 line %0d", i)); end
    drive(8'h5A, 32'h0008_0680, 32'h4000_0001); full("R6 mixed");
    drive(0, 0, 0); full("R4 deassert");

    // R7: bank 0 clear of shortcut/summary bits has no effect
    drive(0, 32'h0000_0201, 32'h0020_0000);
    wr(6'h24, 32'hFFFF_FF00); full("R7 b0 clr upper ignored");
    wr(6'h1C, 32'h0000_0200); m_e1[9] = 1'b0; full("R7 own bank masks shortcut");
    wr(6'h10, 32'h0000_0200); m_e1[9] = 1'b1;

    // R8 steering register
    wr(6'h0C, 32'hFFFF_FF3F); m_st = 8'h3F;
    rd(6'h0C, d); chk("R8 steer upper zero", d, 32'h3F);

    // R9: all lines active, masks closed
    wr(6'h24, 32'hFF); wr(6'h1C, '1); wr(6'h20, '1); m_e0 = 0; m_e1 = 0; m_e2 = 0;
    drive(8'hFF, '1, '1);
    for (int i = 0; i < 80; i++) begin
      wr(6'h0C, 32'h80 | i); m_st = 8'(32'h80 | i);
      full($sformatf("R8 R9 steer %0d", i));
    end

    // R10: single unmasked line, steered or not
    wr(6'h18, 32'hFF); wr(6'h10, '1); wr(6'h14, '1); m_e0 = '1; m_e1 = '1; m_e2 = '1;
    for (int i = 0; i < 72; i += 7) begin
      drive(i >= 64 ? 8'(1 << (i - 64)) : 8'h0,
            i < 32 ? 32'h1 << i : 32'h0,
            (i >= 32 && i < 64) ? 32'h1 << (i - 32) : 32'h0);
      wr(6'h0C, 32'h80 | i); m_st = 8'(32'h80 | i); full($sformatf("R10 steered %0d", i));
      wr(6'h0C, 32'h00 | i); m_st = 8'(i);           full($sformatf("R10 unsteered %0d", i));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule